// File: doc/BRIEF.md
# Write-Protected Timekeeper Register Bank

This block is the storage back end behind a three-wire serial timekeeper port. It holds seven clock and calendar byte slots, a control register whose top bit is a write-protect flag, a trickle-charge configuration byte and a 31-byte scratch RAM. The serial front end does the bit framing. It hands this block one byte request per cycle: a space select (clock or RAM), a read/write flag, a burst flag, a 5-bit location, a data byte, and a separate end-of-transfer strobe that marks the release of the serial select line.

Single accesses use the supplied location. Burst accesses ignore it and walk an internal index that starts at 0 after every end-of-transfer strobe. Clock-space burst writes are collected in a staging buffer and reach the registers together, on the edge of the eighth byte. RAM burst writes land byte by byte. The charge byte is decoded into an enable, a diode count and a resistor select. Illegal codes or a wrong key force all three off.

Top module: `keeper_regbank`

## Requirements
- R1: After synchronous reset, write-protect is 1, the charge byte and all clock slots and RAM bytes are 0, the read data output is 0, and the charge outputs are off.
- R2: A read of clock location 7 returns write-protect in bit 7 and zeros in bits 6:0. A single write to location 7 loads bit 7 of the data into write-protect and is accepted whatever write-protect holds.
- R3: While write-protect is 1, single writes to clock locations 0 to 6, to the charge byte (clock location 8) and to RAM leave the stored values unchanged.
- R4: With write-protect 0, a single write stores the byte at clock locations 0 to 6, at clock location 8 (charge) or at RAM locations 0 to 30. A read request updates the read data output on the next clock edge, and the output holds between reads.
- R5: Clock locations 9 to 31 and RAM location 31 have no storage. Writes to them are discarded and reads return 0.
- R6: A burst request ignores the location field. The k-th burst request after reset or after the last end-of-transfer strobe addresses location k, counting from 0 and stopping at 31.
- R7: A clock burst write changes no register until its eighth byte arrives. On that edge, slots 0 to 6 and write-protect (bit 7 of byte 8) all take the staged values. Later bytes in the same burst are ignored.
- R8: If write-protect is 1 when the eighth clock burst byte arrives, none of the eight registers changes, and that includes the control register.
- R9: A clock burst write ended by the end-of-transfer strobe before its eighth byte leaves every register unchanged.
- R10: A RAM burst write stores each byte on its own edge when write-protect is 0, even when fewer than 31 bytes are sent. Bytes at index 31 and beyond are ignored.
- R11: Burst transfers never reach the charge byte. Clock burst reads at index 8 and above return 0, and clock burst writes never change it.
- R12: The charge outputs are on only when charge bits 7:4 are 1010, bits 3:2 are 01 or 10, and bits 1:0 are not 00. Diode count is 1 for 01 and 2 for 10, and the resistor select equals bits 1:0. When the outputs are off, the count and the select are 0.
- R13: A burst read returns clock slots 0 to 6 at indices 0 to 6 and the control byte at index 7 in clock space, and the RAM byte at its index in RAM space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A byte request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = burst request, location taken from the internal index |
| req_space | input | 1 | 0 = clock space, 1 = RAM space |
| req_addr | input | 5 | Location for single requests |
| req_wdata | input | 8 | Write data byte |
| req_end | input | 1 | End-of-transfer strobe: rewinds the burst index, discards staged bytes |
| rsp_rdata | output | 8 | Read data, updated one edge after a read request |
| chg_enable | output | 1 | Trickle charging enabled |
| chg_diodes | output | 2 | Number of series diodes (1 or 2), 0 when off |
| chg_res_sel | output | 2 | Selected resistor code, 0 when off |

## Verification
A wrong write-protect or slot value shows up on rsp_rdata on the edge after the next read of that location. A wrong charge byte changes the charge outputs on the edge after the write that set it. A wrong staging buffer stays hidden until the eighth byte commits, and the next read exposes it. A burst index that is off by one moves every burst byte to the wrong location and is visible after the first burst read. The bench keeps a behavioural model of the whole bank and compares read data and charge outputs on every cycle. Directed transfers cover the protect, commit, abort and boundary cases, and a long random mix of transfers follows.

// File: rtl/keeper_pkg.sv
package keeper_pkg;

    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 5;
    localparam int CLK_SLOTS  = 8;
    localparam int RAM_BYTES  = 31;
    localparam int CTRL_LOC   = 7;
    localparam int CHARGE_LOC = 8;
    localparam logic [3:0] CHARGE_KEY = 4'b1010;

    typedef enum logic {
        SPACE_CLOCK = 1'b0,
        SPACE_RAM   = 1'b1
    } space_e;

    typedef struct packed {
        logic                valid;
        logic                write;
        logic                burst;
        space_e              space;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
    } req_t;

    typedef struct packed {
        logic       enable;
        logic [1:0] diodes;
        logic [1:0] res_sel;
    } charge_t;

    // Key in the upper nibble, legal diode code, non-zero resistor code.
    function automatic charge_t decode_charge(input logic [7:0] cfg);
        charge_t res;
        logic    key_ok;
        logic    diode_ok;
        logic    res_ok;
        key_ok   = (cfg[7:4] == CHARGE_KEY);
        diode_ok = (cfg[3:2] == 2'b01) || (cfg[3:2] == 2'b10);
        res_ok   = (cfg[1:0] != 2'b00);
        res      = '0;
        if (key_ok && diode_ok && res_ok) begin
            res.enable  = 1'b1;
            res.diodes  = (cfg[3:2] == 2'b01) ? 2'd1 : 2'd2;
            res.res_sel = cfg[1:0];
        end
        return res;
    endfunction

endpackage

// File: rtl/keeper_burst_stage.sv
module keeper_burst_stage #(
    parameter int DATA_W = keeper_pkg::DATA_W,
    parameter int SLOTS  = keeper_pkg::CLK_SLOTS,
    parameter int IDX_W  = keeper_pkg::ADDR_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         step,
    input  logic                         clear,
    input  logic                         stage_we,
    input  logic [DATA_W-1:0]            wdata,
    output logic [IDX_W-1:0]             idx,
    output logic                         commit,
    output logic [(SLOTS-1)*DATA_W-1:0]  staged_slots,
    output logic                         staged_top_bit
);

    localparam logic [IDX_W-1:0] IDX_MAX = '1;
    localparam logic [IDX_W-1:0] LAST    = IDX_W'(SLOTS - 1);

    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] hold_q [SLOTS-1];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx_q <= '0;
        end else if (step && idx_q != IDX_MAX) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // The buffer needs no clearing on abort: a fresh burst rewrites every
    // entry before the last byte can commit.
    for (genvar g = 0; g < SLOTS - 1; g++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q[g] <= '0;
            end else if (stage_we && idx_q == IDX_W'(g)) begin
                hold_q[g] <= wdata;
            end
        end
        assign staged_slots[g*DATA_W +: DATA_W] = hold_q[g];
    end

    assign idx            = idx_q;
    assign commit         = stage_we && (idx_q == LAST);
    assign staged_top_bit = wdata[DATA_W-1];

    assert_end_rewinds_R9: assert property (@(posedge clk) disable iff (rst)
        clear |=> (idx_q == '0));

    assert_idle_holds_index_R6: assert property (@(posedge clk) disable iff (rst)
        (!step && !clear) |=> $stable(idx_q));

endmodule

// File: rtl/keeper_scratch_ram.sv
module keeper_scratch_ram #(
    parameter int DATA_W = keeper_pkg::DATA_W,
    parameter int DEPTH  = keeper_pkg::RAM_BYTES,
    parameter int AW     = keeper_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0]       mem_q [DEPTH];
    logic [DEPTH*DATA_W-1:0] mem_flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[g] <= '0;
            end else if (we && addr == AW'(g)) begin
                mem_q[g] <= wdata;
            end
        end
        assign mem_flat[g*DATA_W +: DATA_W] = mem_q[g];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (addr == AW'(i)) begin
                rdata = mem_q[i];
            end
        end
    end

    assert_no_store_beyond_R5: assert property (@(posedge clk) disable iff (rst)
        (we && addr >= AW'(DEPTH)) |=> $stable(mem_flat));

    assert_quiet_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mem_flat));

endmodule

// File: rtl/keeper_charge_decode.sv
module keeper_charge_decode
    import keeper_pkg::*;
(
    input  logic [7:0] cfg,
    output charge_t    charge
);

    assign charge = decode_charge(cfg);

endmodule

// File: rtl/keeper_regbank.sv
module keeper_regbank
    import keeper_pkg::*;
#(
    parameter int DW      = keeper_pkg::DATA_W,
    parameter int AW      = keeper_pkg::ADDR_W,
    parameter int NSLOT   = keeper_pkg::CLK_SLOTS,
    parameter int NRAM    = keeper_pkg::RAM_BYTES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_burst,
    input  logic          req_space,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_end,
    output logic [DW-1:0] rsp_rdata,
    output logic          chg_enable,
    output logic [1:0]    chg_diodes,
    output logic [1:0]    chg_res_sel
);

    localparam int TIME_SLOTS = NSLOT - 1;
    localparam logic [AW-1:0] CTRL_A   = AW'(CTRL_LOC);
    localparam logic [AW-1:0] CHARGE_A = AW'(CHARGE_LOC);

    req_t req;
    assign req = '{valid: req_valid, write: req_write, burst: req_burst,
                   space: space_e'(req_space), addr: req_addr, data: req_wdata};

    // ---------------- burst index and clock staging ----------------
    logic [AW-1:0]              burst_idx;
    logic                       stage_commit;
    logic [TIME_SLOTS*DW-1:0]   staged_slots;
    logic                       staged_wp;
    logic                       clk_burst_wr;

    assign clk_burst_wr = req.valid && req.write && req.burst && (req.space == SPACE_CLOCK);

    keeper_burst_stage #(.DATA_W(DW), .SLOTS(NSLOT), .IDX_W(AW)) i_stage (
        .clk            (clk),
        .rst            (rst),
        .step           (req.valid && req.burst),
        .clear          (req_end),
        .stage_we       (clk_burst_wr),
        .wdata          (req.data),
        .idx            (burst_idx),
        .commit         (stage_commit),
        .staged_slots   (staged_slots),
        .staged_top_bit (staged_wp)
    );

    logic [AW-1:0] loc;
    logic          single_wr;
    logic          clk_single_wr;
    assign loc           = req.burst ? burst_idx : req.addr;
    assign single_wr     = req.valid && req.write && !req.burst;
    assign clk_single_wr = single_wr && (req.space == SPACE_CLOCK);

    // ---------------- write-protect gate ----------------
    logic wp_q;
    logic burst_apply;
    assign burst_apply = stage_commit && !wp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q <= 1'b1;
        end else if (clk_single_wr && loc == CTRL_A) begin
            wp_q <= req.data[DW-1];
        end else if (burst_apply) begin
            wp_q <= staged_wp;
        end
    end

    // ---------------- clock slots ----------------
    logic [DW-1:0]            slot_q [TIME_SLOTS];
    logic [TIME_SLOTS*DW-1:0] slot_flat;

    for (genvar g = 0; g < TIME_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (burst_apply) begin
                slot_q[g] <= staged_slots[g*DW +: DW];
            end else if (clk_single_wr && !wp_q && loc == AW'(g)) begin
                slot_q[g] <= req.data;
            end
        end
        assign slot_flat[g*DW +: DW] = slot_q[g];
    end

    // ---------------- charge configuration ----------------
    logic [7:0] charge_q;
    charge_t    charge;

    always_ff @(posedge clk) begin
        if (rst) begin
            charge_q <= '0;
        end else if (clk_single_wr && !wp_q && loc == CHARGE_A) begin
            charge_q <= req.data[7:0];
        end
    end

    keeper_charge_decode i_charge (
        .cfg    (charge_q),
        .charge (charge)
    );

    assign chg_enable  = charge.enable;
    assign chg_diodes  = charge.diodes;
    assign chg_res_sel = charge.res_sel;

    // ---------------- scratch RAM ----------------
    logic          ram_we;
    logic [DW-1:0] ram_rdata;
    assign ram_we = req.valid && req.write && (req.space == SPACE_RAM) && !wp_q;

    keeper_scratch_ram #(.DATA_W(DW), .DEPTH(NRAM), .AW(AW)) i_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (ram_we),
        .addr  (loc),
        .wdata (req.data),
        .rdata (ram_rdata)
    );

    // ---------------- read path ----------------
    logic [DW-1:0] rd_next;

    always_comb begin
        rd_next = '0;
        if (req.space == SPACE_RAM) begin
            rd_next = ram_rdata;
        end else if (loc == CTRL_A) begin
            rd_next = {wp_q, {(DW-1){1'b0}}};
        end else if (loc == CHARGE_A && !req.burst) begin
            rd_next = charge_q;
        end else begin
            for (int i = 0; i < TIME_SLOTS; i++) begin
                if (loc == AW'(i)) begin
                    rd_next = slot_q[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_rdata <= '0;
        end else if (req.valid && !req.write) begin
            rsp_rdata <= rd_next;
        end
    end

    // ---------------- assertions ----------------
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wp_q && charge_q == 8'h00 && rsp_rdata == '0));

    assert_ctrl_low_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !req_burst && !req_space && req_addr == CTRL_A)
        |=> (rsp_rdata[DW-2:0] == '0));

    assert_wp_freeze_R3: assert property (@(posedge clk) disable iff (rst)
        wp_q |=> ($stable(slot_flat) && $stable(charge_q)));

    assert_no_early_commit_R7: assert property (@(posedge clk) disable iff (rst)
        (clk_burst_wr && burst_idx < AW'(NSLOT - 1)) |=> $stable(slot_flat));

    assert_burst_skips_charge_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_burst) |=> $stable(charge_q));

    assert_charge_off_zero_R12: assert property (@(posedge clk) disable iff (rst)
        !chg_enable |-> (chg_diodes == 2'd0 && chg_res_sel == 2'd0));

    assert_charge_on_legal_R12: assert property (@(posedge clk) disable iff (rst)
        chg_enable |-> ($countones(chg_diodes) == 1 && chg_res_sel != 2'd0));

endmodule

// File: tb/test_keeper_regbank.sv
module test_keeper_regbank;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic       req_burst = 1'b0;
    logic       req_space = 1'b0;
    logic [4:0] req_addr  = '0;
    logic [7:0] req_wdata = '0;
    logic       req_end   = 1'b0;
    logic [7:0] rsp_rdata;
    logic       chg_enable;
    logic [1:0] chg_diodes;
    logic [1:0] chg_res_sel;

    always #2.5 clk = ~clk;

    keeper_regbank i_keeper_regbank (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_burst(req_burst),
        .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_end(req_end), .rsp_rdata(rsp_rdata), .chg_enable(chg_enable),
        .chg_diodes(chg_diodes), .chg_res_sel(chg_res_sel)
    );

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    bit    started = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference ----------------
    byte unsigned m_slot [7];
    byte unsigned m_ram  [31];
    byte unsigned m_charge;
    bit           m_wp;
    byte unsigned m_rdata;
    int           m_idx;
    byte unsigned m_stage [$];

    function automatic byte unsigned model_read(bit sp, int where, bit burst);
        if (sp) return (where < 31) ? m_ram[where] : 8'h00;
        if (where < 7) return m_slot[where];
        if (where == 7) return m_wp ? 8'h80 : 8'h00;
        if (where == 8 && !burst) return m_charge;
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        int where;
        if (rst) begin
            foreach (m_slot[i]) m_slot[i] = 0;
            foreach (m_ram[i])  m_ram[i]  = 0;
            m_charge = 0; m_wp = 1; m_rdata = 0; m_idx = 0;
            m_stage.delete();
        end else begin
            if (req_valid) begin
                where = req_burst ? m_idx : int'(req_addr);
                if (!req_write) begin
                    m_rdata = model_read(req_space, where, req_burst);
                end else if (!req_space) begin
                    if (req_burst) begin
                        if (m_idx < 8) m_stage.push_back(req_wdata);
                        if (m_idx == 7 && !m_wp) begin
                            for (int i = 0; i < 7; i++) m_slot[i] = m_stage[i];
                            m_wp = m_stage[7][7];
                        end
                    end else if (where == 7) begin
                        m_wp = req_wdata[7];
                    end else if (!m_wp) begin
                        if (where < 7) m_slot[where] = req_wdata;
                        else if (where == 8) m_charge = req_wdata;
                    end
                end else if (!m_wp && where < 31) begin
                    m_ram[where] = req_wdata;
                end
                if (req_burst && m_idx < 31) m_idx++;
            end
            if (req_end) begin
                m_idx = 0;
                m_stage.delete();
            end
        end
        started = 1;
    end

    function automatic void exp_charge(output bit en, output int dio, output int rs);
        int key;
        int ds;
        key = m_charge >> 4;
        ds  = (m_charge >> 2) & 3;
        rs  = m_charge & 3;
        en  = (key == 10) && (ds == 1 || ds == 2) && (rs != 0);
        dio = en ? ds : 0;
        if (!en) rs = 0;
    endfunction

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        bit e_en;
        int e_dio;
        int e_rs;
        if (started) begin
            exp_charge(e_en, e_dio, e_rs);
            checks++;
            if (rsp_rdata !== m_rdata) begin
                fails++;
                $display("FAIL %s read data actual=%02h expected=%02h t=%0t", cur_req, rsp_rdata, m_rdata, $time);
            end
            checks++;
            if (chg_enable !== e_en || chg_diodes !== 2'(e_dio) || chg_res_sel !== 2'(e_rs)) begin
                fails++;
                $display("FAIL %s charge actual=%b/%0d/%0d expected=%b/%0d/%0d t=%0t",
                         cur_req, chg_enable, chg_diodes, chg_res_sel, e_en, e_dio, e_rs, $time);
            end
        end
    end

    // ---------------- drivers ----------------
    task automatic put(input bit sp, input bit wr, input bit bu, input int a, input int d);
        @(posedge clk); #1;
        req_valid = 1; req_space = sp; req_write = wr; req_burst = bu;
        req_addr = 5'(a); req_wdata = 8'(d); req_end = 0;
    endtask

    task automatic idle();
        @(posedge clk); #1;
        req_valid = 0; req_end = 0;
    endtask

    task automatic end_xfer();
        @(posedge clk); #1;
        req_valid = 0; req_end = 1;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog %s actual=%0d cycles expected=done", cur_req, cycles);
            report();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;

        cur_req = "R1";  // reset state: control reads 0x80
        idle(); put(0, 0, 0, 7, 0); idle(); put(0, 0, 0, 3, 0); put(1, 0, 0, 5, 0); idle();

        cur_req = "R2";  // control writable while protected, low bits read 0
        put(0, 1, 0, 7, 8'h7F); put(0, 0, 0, 7, 0); put(0, 1, 0, 7, 8'hFF); put(0, 0, 0, 7, 0);

        cur_req = "R3";  // protected writes ignored
        put(0, 1, 0, 2, 8'h55); put(0, 1, 0, 8, 8'hA5); put(1, 1, 0, 3, 8'h11);
        put(0, 0, 0, 2, 0); put(0, 0, 0, 8, 0); put(1, 0, 0, 3, 0);
        put(0, 1, 0, 7, 8'h00); idle();

        cur_req = "R4";  // unprotected single writes and read-back
        for (int i = 0; i < 7; i++) put(0, 1, 0, i, 8'h10 + i * 8'h11);
        put(0, 1, 0, 8, 8'hA5); put(1, 1, 0, 0, 8'h3C); put(1, 1, 0, 15, 8'hC3); put(1, 1, 0, 30, 8'h99);
        for (int i = 0; i < 9; i++) put(0, 0, 0, i, 0);
        put(1, 0, 0, 0, 0); idle(); idle(); put(1, 0, 0, 15, 0); put(1, 0, 0, 30, 0);

        cur_req = "R12"; // charge decoding over legal and illegal codes
        begin
            byte unsigned codes [12] = '{8'hA5, 8'hA9, 8'hA7, 8'hAB, 8'hA4, 8'hA1,
                                        8'hAD, 8'h55, 8'hB5, 8'hA6, 8'hAA, 8'h00};
            foreach (codes[i]) begin put(0, 1, 0, 8, codes[i]); idle(); end
        end
        put(0, 1, 0, 8, 8'hA6);

        cur_req = "R5";  // locations without storage
        put(0, 1, 0, 9, 8'hEE); put(0, 1, 0, 20, 8'hEE); put(0, 1, 0, 31, 8'hEE); put(1, 1, 0, 31, 8'hEE);
        put(0, 0, 0, 9, 0); put(0, 0, 0, 20, 0); put(0, 0, 0, 31, 0); put(1, 0, 0, 31, 0);

        cur_req = "R7";  // full clock burst with extra bytes; addr field ignored (R6)
        end_xfer();
        for (int i = 0; i < 7; i++) put(0, 1, 1, 19, 8'h40 + i);
        put(0, 1, 1, 3, 8'h00);
        put(0, 1, 1, 0, 8'hFF); put(0, 1, 1, 0, 8'hFF); end_xfer();

        cur_req = "R13"; // clock burst read; index 8 and 9 return 0 (R11)
        for (int i = 0; i < 10; i++) put(0, 0, 1, 8, 0);
        end_xfer();

        cur_req = "R9";  // aborted clock burst
        for (int i = 0; i < 5; i++) put(0, 1, 1, 0, 8'h77);
        end_xfer();
        for (int i = 0; i < 8; i++) put(0, 0, 1, 0, 0);
        end_xfer();

        cur_req = "R8";  // protected clock burst, control byte clears wp but must not land
        put(0, 1, 0, 7, 8'h80); end_xfer();
        for (int i = 0; i < 7; i++) put(0, 1, 1, 0, 8'h22);
        put(0, 1, 1, 0, 8'h00); end_xfer();
        for (int i = 0; i < 8; i++) put(0, 0, 1, 0, 0);
        end_xfer(); put(0, 1, 0, 7, 8'h00);

        cur_req = "R10"; // short RAM burst, then an overlong one
        end_xfer();
        for (int i = 0; i < 4; i++) begin put(1, 1, 1, 0, 8'hD0 + i); put(1, 0, 0, i, 0); end
        end_xfer();
        for (int i = 0; i < 33; i++) put(1, 1, 1, 0, 8'h60 + i);
        end_xfer();

        cur_req = "R6";  // RAM burst read walks index, stops past 31
        for (int i = 0; i < 34; i++) put(1, 0, 1, 31 - (i % 32), 0);
        end_xfer();

        cur_req = "R11"; // clock burst writes never touch charge
        put(0, 1, 0, 8, 8'hA9); end_xfer();
        for (int i = 0; i < 12; i++) put(0, 1, 1, 8, 8'h05);
        end_xfer(); put(0, 0, 0, 8, 0); idle();

        cur_req = "R4";  // random transfers of one kind each
        for (int t = 0; t < 400; t++) begin
            int kind;
            int len;
            kind = $urandom_range(0, 5);
            len  = $urandom_range(1, 12);
            if (kind < 2) begin
                put(0, kind[0], 0, $urandom_range(0, 31), $urandom_range(0, 255));
                if (kind == 1 && $urandom_range(0, 3) == 0) put(0, 1, 0, 7, 8'h00);
            end else if (kind == 2) begin
                put(1, $urandom_range(0, 1), 0, $urandom_range(0, 31), $urandom_range(0, 255));
            end else begin
                bit wr;
                bit sp;
                wr = $urandom_range(0, 1);
                sp = (kind == 5);
                for (int i = 0; i < len; i++) put(sp, wr, 1, $urandom_range(0, 31), $urandom_range(0, 255));
            end
            end_xfer();
        end
        idle(); idle();
        report();
    end

endmodule